// File: doc/BRIEF.md
# Pending Event Record Queue

This block collects device events for an I/O host bridge. It holds them in order until a consumer pulls them out one record at a time. Two kinds of event enter the queue. Error events come straight from a producer port. Availability events are generated inside the block by a small sequencer that turns attach and detach requests for a device slot into the required ordered series of state-transition events. Every record that enters the queue raises a one-cycle notification strobe toward the host side. A level flag tells the consumer whether anything is waiting.

A pop request returns one record a cycle later, with a status bit that says whether a record was there. Multi-byte record fields leave the block as big-endian byte images, so they can be copied straight into a response block in memory. Storage is a fixed-depth register FIFO. A push that finds the FIFO full is lost and sets a sticky overflow flag, which software clears.

Top module: `dev_event_queue`

## Requirements
- R1: After reset, has_event, ovf, notify, pop_done and seq_busy are all 0.
- R2: Records leave in the order they were accepted, one per pop_req. pop_done rises in the cycle after pop_req, and has_event is high exactly when at least one record is stored.
- R3: An error record has rec_class 1 and carries the pushed event code, function ID, function handle, qualifier word and faulting address unchanged.
- R4: An availability record has rec_class 2, and its rec_qual and rec_addr are zero.
- R5: A pop on an empty queue returns pop_status 1 with rec_class 0 and every record field zero. A pop that finds a record returns pop_status 0.
- R6: notify pulses for one cycle in the cycle after each accepted push, and stays low for a push that is dropped.
- R7: Multi-byte record outputs are big-endian images: bits [7:0] hold the most significant byte. rec_len always carries REC_LEN (default 40) in that same byte order.
- R8: A push into a full queue is dropped and sets ovf. ovf stays set until ovf_clr, and a new drop in the same cycle as ovf_clr wins. A push in the same cycle as a successful pop on a full queue is accepted.
- R9: attach_req stores dev_fid and dev_fh for dev_slot, marks the slot configured, and then emits availability events 0x0301 (reserved to standby) followed by 0x0302 (standby to configured).
- R10: detach_req emits 0x0304 (configured to standby) only when the slot is configured, and then always emits 0x0308 (standby to reserved). After that the slot's stored ID and handle read as zero, so a later detach reports zeros.
- R11: cfg_req writes cfg_val into the slot's configured state. attach_req, detach_req and cfg_req are taken only while seq_busy is low and are otherwise ignored. Priority is attach, then detach, then configure.
- R12: When an error push meets a sequencer event in the same cycle, the sequencer event is queued first and the error is queued in the next cycle. While an error is held, the sequencer waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_push | input | 1 | Push one error event |
| err_code | input | 16 | Error event code |
| err_fid | input | 32 | Function ID of the failing device |
| err_fh | input | 32 | Function handle of the failing device |
| err_qual | input | 32 | Error qualifier word |
| err_addr | input | ADDR_W | Faulting address |
| attach_req | input | 1 | Attach the device in dev_slot |
| detach_req | input | 1 | Detach the device in dev_slot |
| cfg_req | input | 1 | Write the configured state of dev_slot |
| cfg_val | input | 1 | Configured state to write |
| dev_slot | input | SLOT_W | Device slot for the sequencer requests |
| dev_fid | input | 32 | Function ID stored on attach |
| dev_fh | input | 32 | Function handle stored on attach |
| seq_busy | output | 1 | Sequencer is emitting events |
| pop_req | input | 1 | Take one record |
| has_event | output | 1 | At least one record is stored |
| pop_done | output | 1 | Record outputs are valid for the last pop |
| pop_status | output | 1 | 0 record returned, 1 no event |
| rec_len | output | 16 | Fixed record length, big-endian |
| rec_class | output | 8 | 1 error, 2 availability, 0 none |
| rec_code | output | 16 | Event code, big-endian |
| rec_fid | output | 32 | Function ID, big-endian |
| rec_fh | output | 32 | Function handle, big-endian |
| rec_qual | output | 32 | Qualifier word, big-endian |
| rec_addr | output | ADDR_W | Faulting address, big-endian |
| notify | output | 1 | One-cycle strobe per accepted push |
| ovf | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clear the overflow flag |

## Verification
The bench targets the cycles where two things meet.

An error push that collides with a sequencer event must land right after it. A design that gave the error priority, or dropped it, would show the wrong record order or a missing record. A pop in the same cycle as a push into a full queue must keep the push. A design that checked fullness before the pop would raise ovf and lose the record. Overflow set and clear in one cycle must leave ovf set.

Detach of an unconfigured slot must produce a single event, and a repeated detach must report a zeroed ID and handle. A sequencer that always emitted both events, or kept stale identifiers, shows up directly in the popped codes. Byte order is checked on every record field, so a swapped or unswapped lane is caught at once.

// File: rtl/dev_event_queue.sv
module dev_event_queue #(
  parameter int          DEPTH       = 8,
  parameter int          SLOTS       = 4,
  parameter int          ADDR_W      = 64,
  parameter logic [15:0] REC_LEN     = 16'd40,
  parameter logic [15:0] EV_RSV_STBY = 16'h0301,
  parameter logic [15:0] EV_STBY_CFG = 16'h0302,
  parameter logic [15:0] EV_CFG_STBY = 16'h0304,
  parameter logic [15:0] EV_STBY_RSV = 16'h0308,
  localparam int         SLOT_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_push,
  input  logic [15:0]       err_code,
  input  logic [31:0]       err_fid,
  input  logic [31:0]       err_fh,
  input  logic [31:0]       err_qual,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              attach_req,
  input  logic              detach_req,
  input  logic              cfg_req,
  input  logic              cfg_val,
  input  logic [SLOT_W-1:0] dev_slot,
  input  logic [31:0]       dev_fid,
  input  logic [31:0]       dev_fh,
  output logic              seq_busy,
  input  logic              pop_req,
  output logic              has_event,
  output logic              pop_done,
  output logic              pop_status,
  output logic [15:0]       rec_len,
  output logic [7:0]        rec_class,
  output logic [15:0]       rec_code,
  output logic [31:0]       rec_fid,
  output logic [31:0]       rec_fh,
  output logic [31:0]       rec_qual,
  output logic [ADDR_W-1:0] rec_addr,
  output logic              notify,
  output logic              ovf,
  input  logic              ovf_clr
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AB    = ADDR_W / 8;

  typedef enum logic [2:0] {S_IDLE, S_ATT_A, S_ATT_B, S_DET_A, S_DET_B} seq_t;

  // queue storage
  logic              q_err  [DEPTH];
  logic [15:0]       q_code [DEPTH];
  logic [31:0]       q_fid  [DEPTH];
  logic [31:0]       q_fh   [DEPTH];
  logic [31:0]       q_qual [DEPTH];
  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;

  // slot table and sequencer
  logic [31:0]       t_fid [SLOTS];
  logic [31:0]       t_fh  [SLOTS];
  logic              t_cfg [SLOTS];
  seq_t              st;
  logic [SLOT_W-1:0] slot;

  // held error
  logic              hold_v;
  logic [15:0]       h_code;
  logic [31:0]       h_fid, h_fh, h_qual;
  logic [ADDR_W-1:0] h_addr;

  // push source
  logic              p_v, p_err;
  logic [15:0]       p_code, seq_code;
  logic [31:0]       p_fid, p_fh, p_qual;
  logic [ADDR_W-1:0] p_addr;

  // native record registers
  logic [15:0]       rd_code;
  logic [31:0]       rd_fid, rd_fh, rd_qual;
  logic [ADDR_W-1:0] rd_addr;

  logic full, pop_ok, push_ok, drop, err_blocked, seq_go;

  assign full        = (count == CNT_W'(DEPTH));
  assign has_event   = (count != '0);
  assign pop_ok      = pop_req && has_event;
  assign push_ok     = p_v && (!full || pop_ok);
  assign drop        = p_v && !push_ok;
  assign seq_busy    = (st != S_IDLE);
  assign seq_go      = seq_busy && !hold_v;
  assign err_blocked = err_push && (hold_v || seq_busy);

  always_comb begin
    case (st)
      S_ATT_A: seq_code = EV_RSV_STBY;
      S_ATT_B: seq_code = EV_STBY_CFG;
      S_DET_A: seq_code = EV_CFG_STBY;
      default: seq_code = EV_STBY_RSV;
    endcase
  end

  always_comb begin
    p_v = 1'b0; p_err = 1'b1; p_code = err_code; p_fid = err_fid;
    p_fh = err_fh; p_qual = err_qual; p_addr = err_addr;
    if (hold_v) begin
      p_v = 1'b1; p_code = h_code; p_fid = h_fid;
      p_fh = h_fh; p_qual = h_qual; p_addr = h_addr;
    end else if (seq_busy) begin
      p_v = 1'b1; p_err = 1'b0; p_code = seq_code; p_fid = t_fid[slot];
      p_fh = t_fh[slot]; p_qual = '0; p_addr = '0;
    end else if (err_push) begin
      p_v = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_err[wptr]  <= p_err;
      q_code[wptr] <= p_code;
      q_fid[wptr]  <= p_fid;
      q_fh[wptr]   <= p_fh;
      q_qual[wptr] <= p_qual;
      q_addr[wptr] <= p_addr;
    end
    if (err_blocked) begin
      h_code <= err_code; h_fid <= err_fid; h_fh <= err_fh;
      h_qual <= err_qual; h_addr <= err_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0;
      notify <= 1'b0; ovf <= 1'b0; hold_v <= 1'b0;
      pop_done <= 1'b0; pop_status <= 1'b0; rec_class <= '0;
      rd_code <= '0; rd_fid <= '0; rd_fh <= '0; rd_qual <= '0; rd_addr <= '0;
    end else begin
      if (push_ok) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count  <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      notify <= push_ok;
      hold_v <= err_blocked;
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      pop_done <= pop_req;
      if (pop_req) begin
        if (pop_ok) begin
          pop_status <= 1'b0;
          rec_class  <= q_err[rptr] ? 8'd1 : 8'd2;
          rd_code <= q_code[rptr]; rd_fid <= q_fid[rptr]; rd_fh <= q_fh[rptr];
          rd_qual <= q_qual[rptr]; rd_addr <= q_addr[rptr];
        end else begin
          pop_status <= 1'b1;
          rec_class  <= '0;
          rd_code <= '0; rd_fid <= '0; rd_fh <= '0; rd_qual <= '0; rd_addr <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      slot <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        t_fid[i] <= '0; t_fh[i] <= '0; t_cfg[i] <= 1'b0;
      end
    end else if (st == S_IDLE) begin
      if (attach_req) begin
        slot <= dev_slot;
        t_fid[dev_slot] <= dev_fid;
        t_fh[dev_slot]  <= dev_fh;
        t_cfg[dev_slot] <= 1'b1;
        st <= S_ATT_A;
      end else if (detach_req) begin
        slot <= dev_slot;
        st <= t_cfg[dev_slot] ? S_DET_A : S_DET_B;
      end else if (cfg_req) begin
        t_cfg[dev_slot] <= cfg_val;
      end
    end else if (seq_go) begin
      case (st)
        S_ATT_A: st <= S_ATT_B;
        S_DET_A: begin
          t_cfg[slot] <= 1'b0;
          st <= S_DET_B;
        end
        S_DET_B: begin
          t_fid[slot] <= '0; t_fh[slot] <= '0; t_cfg[slot] <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // big-endian byte images: output byte 0 carries the top byte
  for (genvar b = 0; b < 2; b++) begin : g_be16
    assign rec_len[8*b +: 8]  = REC_LEN[15-8*b -: 8];
    assign rec_code[8*b +: 8] = rd_code[15-8*b -: 8];
  end
  for (genvar b = 0; b < 4; b++) begin : g_be32
    assign rec_fid[8*b +: 8]  = rd_fid[31-8*b -: 8];
    assign rec_fh[8*b +: 8]   = rd_fh[31-8*b -: 8];
    assign rec_qual[8*b +: 8] = rd_qual[31-8*b -: 8];
  end
  for (genvar b = 0; b < AB; b++) begin : g_bea
    assign rec_addr[8*b +: 8] = rd_addr[ADDR_W-1-8*b -: 8];
  end
endmodule

module dev_event_queue_chk #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pop_req,
  input logic              has_event,
  input logic              pop_done,
  input logic              pop_status,
  input logic [7:0]        rec_class,
  input logic [31:0]       rec_qual,
  input logic [ADDR_W-1:0] rec_addr,
  input logic              ovf,
  input logic              ovf_clr,
  input logic              attach_req,
  input logic              seq_busy,
  input logic [CNT_W-1:0]  count
);
  p_empty_pop_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && !has_event |=> pop_done && pop_status);
  p_full_pop_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && has_event |=> pop_done && !pop_status);
  p_empty_rec_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done && pop_status |-> rec_class == 8'd0 && rec_qual == '0 && rec_addr == '0);
  p_avail_fields_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done && !pop_status && rec_class == 8'd2 |-> rec_qual == '0 && rec_addr == '0);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_attach_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_busy && attach_req |=> seq_busy);
endmodule

bind dev_event_queue dev_event_queue_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .has_event(has_event),
  .pop_done(pop_done), .pop_status(pop_status), .rec_class(rec_class),
  .rec_qual(rec_qual), .rec_addr(rec_addr), .ovf(ovf), .ovf_clr(ovf_clr),
  .attach_req(attach_req), .seq_busy(seq_busy), .count(count)
);

// File: tb/dev_event_queue_tb_top.sv
module dev_event_queue_tb_top;
  localparam int          DEPTH = 8;
  localparam logic [15:0] LEN   = 16'd40;

  typedef struct packed {
    logic        err;
    logic [15:0] code;
    logic [31:0] fid;
    logic [31:0] fh;
    logic [31:0] qual;
    logic [63:0] addr;
  } ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic err_push = 0, attach_req = 0, detach_req = 0, cfg_req = 0, cfg_val = 0;
  logic pop_req = 0, ovf_clr = 0;
  logic [15:0] err_code = 0;
  logic [31:0] err_fid = 0, err_fh = 0, err_qual = 0, dev_fid = 0, dev_fh = 0;
  logic [63:0] err_addr = 0;
  logic [1:0]  dev_slot = 0;
  logic seq_busy, has_event, pop_done, pop_status, notify, ovf;
  logic [15:0] rec_len, rec_code;
  logic [7:0]  rec_class;
  logic [31:0] rec_fid, rec_fh, rec_qual;
  logic [63:0] rec_addr;

  dev_event_queue dut_i (
    .clk(clk), .rst_n(rst_n), .err_push(err_push), .err_code(err_code),
    .err_fid(err_fid), .err_fh(err_fh), .err_qual(err_qual), .err_addr(err_addr),
    .attach_req(attach_req), .detach_req(detach_req), .cfg_req(cfg_req),
    .cfg_val(cfg_val), .dev_slot(dev_slot), .dev_fid(dev_fid), .dev_fh(dev_fh),
    .seq_busy(seq_busy), .pop_req(pop_req), .has_event(has_event),
    .pop_done(pop_done), .pop_status(pop_status), .rec_len(rec_len),
    .rec_class(rec_class), .rec_code(rec_code), .rec_fid(rec_fid), .rec_fh(rec_fh),
    .rec_qual(rec_qual), .rec_addr(rec_addr), .notify(notify), .ovf(ovf),
    .ovf_clr(ovf_clr)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string ph_tag = "R3";

  // reference model state
  ev_t q[$];
  ev_t m_hold, e_rec;
  bit  m_hold_v = 0, e_done = 0, e_stat = 0, e_notify = 0, e_ovf = 0;
  logic [7:0] e_cls = 0;
  int  m_st = 0, m_slot = 0;
  logic [31:0] t_fid[4] = '{default: 0};
  logic [31:0] t_fh[4]  = '{default: 0};
  bit          t_cfg[4] = '{default: 0};

  function automatic logic [63:0] bsw(input logic [63:0] v, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = v[8*(n-1-i) +: 8];
    return r;
  endfunction

  function automatic logic [15:0] st_code(input int s);
    case (s)
      1: return 16'h0301;
      2: return 16'h0302;
      3: return 16'h0304;
      default: return 16'h0308;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    ev_t pv, hn;
    bit pushv, blocked, go;
    if (pop_req) begin
      e_done = 1;
      if (q.size() > 0) begin
        e_rec = q.pop_front(); e_stat = 0; e_cls = e_rec.err ? 8'd1 : 8'd2;
      end else begin
        e_rec = '0; e_stat = 1; e_cls = 0;
      end
    end else e_done = 0;
    hn = '{1'b1, err_code, err_fid, err_fh, err_qual, err_addr};
    pushv = 0; pv = '0;
    blocked = err_push && (m_hold_v || m_st != 0);
    go = (m_st != 0) && !m_hold_v;
    if (m_hold_v) begin pv = m_hold; pushv = 1; end
    else if (m_st != 0) begin
      pv = '{1'b0, st_code(m_st), t_fid[m_slot], t_fh[m_slot], 32'd0, 64'd0};
      pushv = 1;
    end else if (err_push) begin pv = hn; pushv = 1; end
    if (blocked) m_hold = hn;
    m_hold_v = blocked;
    e_notify = 0;
    if (pushv && q.size() < DEPTH) begin q.push_back(pv); e_notify = 1; end
    if (pushv && !e_notify) e_ovf = 1;
    else if (ovf_clr) e_ovf = 0;
    if (m_st == 0) begin
      if (attach_req) begin
        m_slot = dev_slot; t_fid[dev_slot] = dev_fid; t_fh[dev_slot] = dev_fh;
        t_cfg[dev_slot] = 1; m_st = 1;
      end else if (detach_req) begin
        m_slot = dev_slot; m_st = t_cfg[dev_slot] ? 3 : 4;
      end else if (cfg_req) t_cfg[dev_slot] = cfg_val;
    end else if (go) begin
      case (m_st)
        1: m_st = 2;
        3: begin t_cfg[m_slot] = 0; m_st = 4; end
        4: begin t_fid[m_slot] = 0; t_fh[m_slot] = 0; t_cfg[m_slot] = 0; m_st = 0; end
        default: m_st = 0;
      endcase
    end
  endtask

  task automatic compare();
    string ft;
    ft = (e_cls == 8'd2) ? "R4" : ph_tag;
    chk("R2", "has_event", has_event, q.size() != 0);
    chk("R6", "notify", notify, e_notify);
    chk("R8", "ovf", ovf, e_ovf);
    chk("R11", "seq_busy", seq_busy, m_st != 0);
    chk("R5", "pop_done", pop_done, e_done);
    chk("R5", "pop_status", pop_status, e_stat);
    chk(ph_tag, "rec_class", rec_class, e_cls);
    chk(ph_tag, "rec_code", rec_code, bsw(e_rec.code, 2));
    chk(ph_tag, "rec_fid", rec_fid, bsw(e_rec.fid, 4));
    chk(ph_tag, "rec_fh", rec_fh, bsw(e_rec.fh, 4));
    chk(ft, "rec_qual", rec_qual, bsw(e_rec.qual, 4));
    chk(ft, "rec_addr", rec_addr, bsw(e_rec.addr, 8));
    chk("R7", "rec_len", rec_len, bsw(LEN, 2));
  endtask

  task automatic step();
    @(posedge clk);
    model();
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic push_err(input logic [15:0] c, input logic [31:0] f, input logic [63:0] a);
    err_push = 1; err_code = c; err_fid = f; err_fh = f ^ 32'h8000_0000;
    err_qual = {f[15:0], c}; err_addr = a;
    step();
    err_push = 0;
  endtask

  task automatic pop1();
    pop_req = 1; step(); pop_req = 0;
  endtask

  task automatic attach(input logic [1:0] s, input logic [31:0] f);
    attach_req = 1; dev_slot = s; dev_fid = f; dev_fh = f | 32'h8000_0000;
    step(); attach_req = 0;
  endtask

  task automatic detach(input logic [1:0] s);
    detach_req = 1; dev_slot = s; step(); detach_req = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "has_event", has_event, 0);
    chk("R1", "ovf", ovf, 0);
    chk("R1", "notify", notify, 0);
    chk("R1", "pop_done", pop_done, 0);
    chk("R1", "seq_busy", seq_busy, 0);
    rst_n = 1;
    step();
    // R5 empty pop
    ph_tag = "R5"; pop1(); idle(1);
    // R2 R3 R7 error records in order
    ph_tag = "R3";
    push_err(16'h003a, 32'h0102_0304, 64'h1122_3344_5566_7788);
    push_err(16'h0010, 32'h00ab_cdef, 64'hfeed_0000_0000_1000);
    push_err(16'h0027, 32'h7700_0001, 64'h0000_0000_dead_beef);
    ph_tag = "R2"; pop1(); pop1(); pop1(); pop1(); idle(1);
    // R9 attach
    ph_tag = "R9"; attach(2'd1, 32'h0000_0011); idle(3);
    pop1(); pop1(); pop1();
    // R10 detach of an unconfigured slot gives one event
    ph_tag = "R10";
    cfg_req = 1; cfg_val = 0; dev_slot = 2'd1; step(); cfg_req = 0;
    detach(2'd1); idle(3); pop1(); pop1();
    attach(2'd2, 32'h0000_0022); idle(3); pop1(); pop1();
    detach(2'd2); idle(3); pop1(); pop1(); pop1();
    detach(2'd2); idle(3); pop1(); pop1();
    // R11 requests during busy are ignored
    ph_tag = "R11";
    attach(2'd3, 32'h0000_0033);
    detach_req = 1; dev_slot = 2'd3; step(); detach_req = 0;
    attach_req = 1; dev_slot = 2'd0; dev_fid = 32'h99; step(); attach_req = 0;
    idle(2); pop1(); pop1(); pop1();
    // R12 collision of sequencer and error push
    ph_tag = "R12";
    attach(2'd0, 32'h0000_0044);
    push_err(16'h0055, 32'h0000_0555, 64'h5555);
    push_err(16'h0056, 32'h0000_0556, 64'h5556);
    idle(3);
    for (int i = 0; i < 5; i++) pop1();
    // R8 overflow, pop-with-push on full, clear
    ph_tag = "R8";
    for (int i = 0; i < DEPTH + 2; i++) push_err(16'h0100 + 16'(i), 32'(i), 64'(i));
    err_push = 1; pop_req = 1; err_code = 16'h0200; step(); err_push = 0; pop_req = 0;
    err_push = 1; ovf_clr = 1; step(); err_push = 0; ovf_clr = 0;
    ovf_clr = 1; step(); ovf_clr = 0;
    for (int i = 0; i < DEPTH + 1; i++) pop1();
    // mixed random traffic
    ph_tag = "R2";
    for (int i = 0; i < 2000; i++) begin
      err_push   = ($urandom % 3) == 0;
      err_code   = 16'($urandom); err_fid = $urandom; err_fh = $urandom;
      err_qual   = $urandom; err_addr = {$urandom, $urandom};
      pop_req    = ($urandom % 3) == 0;
      attach_req = ($urandom % 11) == 0;
      detach_req = ($urandom % 9) == 0;
      cfg_req    = ($urandom % 13) == 0;
      cfg_val    = 1'($urandom);
      dev_slot   = 2'($urandom);
      dev_fid    = $urandom; dev_fh = $urandom;
      ovf_clr    = ($urandom % 17) == 0;
      step();
    end
    err_push = 0; pop_req = 0; attach_req = 0; detach_req = 0; cfg_req = 0; ovf_clr = 0;
    idle(4);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule